// File: doc/BRIEF.md
# Multi-Rate Counter Bank Controller

This block holds three free-running up-counters of 4, 8 and 12 bits and a small control state machine. On every edge of the single fast clock, the state machine gives each counter one of three behaviours. A counter can advance on every fast edge, advance once per slow heartbeat, or hold its value. A 2-bit command input steers the state machine, so the switching activity of the bank rises and falls in steps as the command changes.

The slow heartbeat enters as a plain level on `slow_in`. This is a square wave of roughly 32 kHz, while the fast clock runs in the tens of MHz. The block passes it through a synchroniser and an edge detector and turns each rising edge into a one-cycle enable pulse in the fast domain. There is no second clock tree. Counter values are visible on three output buses at all times.

Top module: `mrc_bank`

## Requirements
- R1: While `rst_n` is low, all three counters read zero. After release, the controller is in the all-hold state.
- R2: `cmd` is sampled on every rising edge, with 00 = all hold, 01 = split, 10 = all fast and 11 = all slow. A command sampled at edge k governs the counters from edge k+1 on; edge k itself still uses the previous state's modes.
- R3: In the all-hold state, no counter changes, whatever `slow_in` does.
- R4: In the all-fast state, every counter advances by one on every clock edge.
- R5: In the all-slow state, every counter advances by one only on edges where the internal slow tick is present, and holds otherwise.
- R6: In the split state, the 4-bit counter runs at the slow rate, the 8-bit counter runs at the fast rate, and the 12-bit counter holds.
- R7: A low-to-high change of `slow_in` first sampled high at edge n produces exactly one slow advance, at edge n+2 (two synchroniser stages). This holds however long `slow_in` then stays high.
- R8: A counter at its all-ones value wraps to zero on its next advance.
- R9: Counter values are kept unchanged across every state change; a new state only alters how they continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| cmd | input | 2 | Next-state command, sampled every cycle |
| slow_in | input | 1 | Slow heartbeat level, asynchronous to `clk` |
| cnt_a | output | W_A (4) | 4-bit counter value |
| cnt_b | output | W_B (8) | 8-bit counter value |
| cnt_c | output | W_C (12) | 12-bit counter value |

## Verification
A command presented before edge k changes the state at k, and the counters first move under the new modes at edge k+1. A heartbeat edge first sampled at edge n reaches the counters at edge n+2. The bench drives every input on the falling edge. At each rising edge, its driver advances its own model with these latencies, using the pre-edge state and tick pipeline, and pushes the expected counter triple into a queue. A monitor pops one entry on each following falling edge and compares it with the outputs. Every result is therefore checked in the exact cycle it is due, including the transition cycles where the old and new modes meet.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'b00,
    ST_SPLIT = 2'b01,
    ST_FAST  = 2'b10,
    ST_SLOW  = 2'b11
  } bank_state_t;

  typedef enum logic [1:0] {
    MD_HOLD = 2'b00,
    MD_FAST = 2'b01,
    MD_SLOW = 2'b10
  } cnt_mode_t;

  localparam int NUM_CNT = 3;

endpackage

// File: rtl/mrc_slow_tick.sv
module mrc_slow_tick
  import mrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic slow_tick
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= slow_in;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  // one pulse per rising edge of the synchronised heartbeat
  assign slow_tick = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/mrc_ctrl_fsm.sv
module mrc_ctrl_fsm
  import mrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmd,
  output bank_state_t state_q
);

  bank_state_t state_d;

  always_comb begin
    unique case (cmd)
      2'b00:   state_d = ST_HOLD;
      2'b01:   state_d = ST_SPLIT;
      2'b10:   state_d = ST_FAST;
      default: state_d = ST_SLOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/mrc_mode_map.sv
module mrc_mode_map
  import mrc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  bank_state_t state,
  output cnt_mode_t   mode
);

  cnt_mode_t split_mode;

  // split state: narrowest slow, middle fast, widest frozen
  if (IDX == 0) begin : g_split_slow
    assign split_mode = MD_SLOW;
  end else if (IDX == 1) begin : g_split_fast
    assign split_mode = MD_FAST;
  end else begin : g_split_hold
    assign split_mode = MD_HOLD;
  end

  always_comb begin
    unique case (state)
      ST_HOLD:  mode = MD_HOLD;
      ST_SPLIT: mode = split_mode;
      ST_FAST:  mode = MD_FAST;
      default:  mode = MD_SLOW;
    endcase
  end

endmodule

// File: rtl/mrc_counter.sv
module mrc_counter
  import mrc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_t        mode,
  input  logic             slow_tick,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic             adv_en;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    adv_en = (mode == MD_FAST) || ((mode == MD_SLOW) && slow_tick);
    cnt_d  = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (adv_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/mrc_bank.sv
module mrc_bank
  import mrc_pkg::*;
#(
  parameter int W_A         = 4,
  parameter int W_B         = 8,
  parameter int W_C         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cmd,
  input  logic           slow_in,
  output logic [W_A-1:0] cnt_a,
  output logic [W_B-1:0] cnt_b,
  output logic [W_C-1:0] cnt_c
);

  localparam int W_TOT = W_A + W_B + W_C;

  bank_state_t      state_q;
  logic             slow_tick;
  logic [W_TOT-1:0] cnt_bus;

  mrc_slow_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_in   (slow_in),
    .slow_tick (slow_tick)
  );

  mrc_ctrl_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .state_q (state_q)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int WI  = (i == 0) ? W_A : ((i == 1) ? W_B : W_C);
    localparam int OFF = (i == 0) ? 0   : ((i == 1) ? W_A : W_A + W_B);

    cnt_mode_t mode;

    mrc_mode_map #(.IDX(i)) u_map (
      .state (state_q),
      .mode  (mode)
    );

    mrc_counter #(.WIDTH(WI)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .slow_tick (slow_tick),
      .count     (cnt_bus[OFF +: WI])
    );
  end

  assign cnt_a = cnt_bus[W_A-1:0];
  assign cnt_b = cnt_bus[W_A +: W_B];
  assign cnt_c = cnt_bus[W_A+W_B +: W_C];

endmodule

// File: rtl/mrc_bank_chk.sv
module mrc_bank_chk
  import mrc_pkg::*;
#(
  parameter int W_A = 4,
  parameter int W_B = 8,
  parameter int W_C = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cmd,
  input bank_state_t    state_q,
  input logic           slow_tick,
  input logic [W_A-1:0] cnt_a,
  input logic [W_B-1:0] cnt_b,
  input logic [W_C-1:0] cnt_c
);

  localparam logic [W_A-1:0] ONE_A = W_A'(1);
  localparam logic [W_B-1:0] ONE_B = W_B'(1);
  localparam logic [W_C-1:0] ONE_C = W_C'(1);

  assert_state_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (state_q == bank_state_t'($past(cmd))));

  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_c)));

  assert_fast_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAST) |=> ((cnt_a == $past(cnt_a) + ONE_A) &&
                              (cnt_b == $past(cnt_b) + ONE_B) &&
                              (cnt_c == $past(cnt_c) + ONE_C)));

  assert_slow_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOW && !slow_tick) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_c)));

  assert_slow_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOW && slow_tick) |=> (cnt_c == $past(cnt_c) + ONE_C));

  assert_split_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPLIT) |=> ($stable(cnt_c) && (cnt_b == $past(cnt_b) + ONE_B)));

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> !slow_tick);

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAST && cnt_a == '1) |=> (cnt_a == '0));

endmodule

bind mrc_bank mrc_bank_chk #(.W_A(W_A), .W_B(W_B), .W_C(W_C)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .state_q   (state_q),
  .slow_tick (slow_tick),
  .cnt_a     (cnt_a),
  .cnt_b     (cnt_b),
  .cnt_c     (cnt_c)
);

// File: tb/tb_mrc_bank.sv
module tb_mrc_bank;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cmd;
  logic        slow_in;
  logic [3:0]  cnt_a;
  logic [7:0]  cnt_b;
  logic [11:0] cnt_c;

  mrc_bank dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .slow_in (slow_in),
    .cnt_a   (cnt_a),
    .cnt_b   (cnt_b),
    .cnt_c   (cnt_c)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [3:0]  a;
    logic [7:0]  b;
    logic [11:0] c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 0;

  // model state
  logic [3:0]  m_a;
  logic [7:0]  m_b;
  logic [11:0] m_c;
  logic [1:0]  m_st;
  logic        m_s1, m_s2, m_s3;

  // 0 hold, 1 fast, 2 slow
  function automatic int mode_of(input int idx, input logic [1:0] st);
    case (st)
      2'b00: return 0;
      2'b01: return (idx == 0) ? 2 : ((idx == 1) ? 1 : 0);
      2'b10: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic bit adv(input int md, input logic pulse);
    return (md == 1) || (md == 2 && pulse);
  endfunction

  task automatic cyc(input logic [1:0] c, input logic s, input string tag);
    logic pulse;
    exp_t e;
    cmd     = c;
    slow_in = s;
    @(posedge clk);
    pulse = m_s2 & ~m_s3;
    if (adv(mode_of(0, m_st), pulse)) m_a = m_a + 4'd1;
    if (adv(mode_of(1, m_st), pulse)) m_b = m_b + 8'd1;
    if (adv(mode_of(2, m_st), pulse)) m_c = m_c + 12'd1;
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = s;
    m_st = c;
    e.a = m_a; e.b = m_b; e.c = m_c; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: pops expectations after each rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (cnt_a !== e.a || cnt_b !== e.b || cnt_c !== e.c) begin
          n_fails++;
          $display("FAIL %s: got a=%0d b=%0d c=%0d expected a=%0d b=%0d c=%0d",
                   e.tag, cnt_a, cnt_b, cnt_c, e.a, e.b, e.c);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog (R1..): run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    m_a = '0; m_b = '0; m_c = '0; m_st = 2'b00;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
    rst_n   = 1'b0;
    cmd     = 2'b10;
    slow_in = 1'b0;
    // R1: reset holds counters at zero even with fast command applied
    repeat (4) begin
      @(negedge clk);
      n_checks++;
      if (cnt_a !== 4'd0 || cnt_b !== 8'd0 || cnt_c !== 12'd0) begin
        n_fails++;
        $display("FAIL R1: in reset got a=%0d b=%0d c=%0d expected 0 0 0", cnt_a, cnt_b, cnt_c);
      end
    end
    cmd = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: hold state after release, heartbeat toggling
    for (int i = 0; i < 8; i++) cyc(2'b00, i[1], "R3 hold after reset R1");

    // R2: fast command; the sampling edge still uses hold
    cyc(2'b10, 1'b0, "R2 first edge uses old state");
    for (int i = 0; i < 10; i++) cyc(2'b10, 1'b0, "R4 all fast");

    // R9 / R6: split with heartbeat pulses
    cyc(2'b01, 1'b0, "R9 fast->split values kept");
    for (int i = 0; i < 24; i++) cyc(2'b01, (i % 6) < 2, "R6 split, R7 tick timing");

    // R5 / R7: all slow, short and long heartbeat highs
    cyc(2'b11, 1'b0, "R9 split->slow values kept");
    for (int i = 0; i < 6; i++)  cyc(2'b11, 1'b0, "R5 slow, no tick");
    cyc(2'b11, 1'b1, "R7 short high");
    for (int i = 0; i < 4; i++)  cyc(2'b11, 1'b0, "R5 slow, after tick");
    for (int i = 0; i < 12; i++) cyc(2'b11, 1'b1, "R7 long high gives one tick");
    for (int i = 0; i < 5; i++)  cyc(2'b11, 1'b0, "R5 slow idle");

    // R9 / R3: back to hold with heartbeat active
    cyc(2'b00, 1'b1, "R9 slow->hold values kept");
    for (int i = 0; i < 10; i++) cyc(2'b00, i[0], "R3 hold ignores heartbeat");

    // R8: long fast run wraps every counter
    for (int i = 0; i < 4200; i++) cyc(2'b10, 1'b0, "R8 wrap in fast");

    // R2: rapid command changes every cycle
    for (int i = 0; i < 16; i++) cyc(2'(i), i[2], "R2 per-cycle command");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule